// File: doc/BRIEF.md
# Multi-Level Radix Table Walker

The walker turns an effective address into a real address by descending a radix tree of 8-byte entries in memory. A translation starts with a process identifier, the base and size code of a process table, and the address to translate. The front stage first checks that the process identifier falls inside the table. It then reads the process-table entry, which supplies the root directory base, the root index width and an encoded tree size. After that the walker steps down one level per memory read until it finds a leaf entry.

Each directory entry names the base and index width of the level below it, so the tree depth and the final page size change from walk to walk. The walker checks the index width at every level before it reads. When the walk ends it presents the real address, the page size in bits, the leaf entry and the leaf entry's own address. It raises a one-cycle `done` strobe, with `fault` and a cause code beside it when the walk failed. Memory is reached through a valid/ready request channel and a response strobe, and only one read is in flight at any time.

Top module: `rdx_walk_top`

## Requirements
- R1: The process-table byte offset is pid × 16 and the table holds 2^(ptab_size + 12) bytes. When the offset is not below that size, the walk ends with fault=1 and fault_cause=2'b01 (no-entry, bit 0), and no memory read is issued.
- R2: The first read goes to ptab_base + pid × 16. In the returned entry, bits [55:8] give the root directory base (its low 8 bits are zero), bits [4:0] give the root index width, and bits [60:56] hold a size code whose value plus 31 is the initial remaining size in bits.
- R3: At each tree level the index is (address >> (remaining − width)) masked to width bits, and the entry is read at base + index × 8.
- R4: Before each tree-level read, an index width below 5, or above the remaining size, ends the walk with fault_cause=2'b10 (bad configuration, bit 1) and no read for that level.
- R5: A fetched tree entry with bit 63 (valid) clear ends the walk with fault_cause=2'b01.
- R6: After each tree-level fetch, the remaining size drops by that level's width. A valid entry with bit 62 (leaf) clear supplies the next base from bits [55:8] and the next width from bits [4:0].
- R7: On a valid leaf, psize equals the remaining size, and raddr = ({entry[55:12], 12'b0} AND NOT mask) OR (address AND mask), where mask = 2^psize − 1. leaf_pte is the entry and pte_addr is the address it was read from.
- R8: A walk that has read 8 tree levels without finding a leaf ends with fault_cause=2'b10. A leaf found at the eighth level is still accepted.
- R9: done is high for exactly one cycle per walk. fault is high only together with done, and then exactly one cause bit is set. After reset, done, fault and req_valid are low.
- R10: At most one read is outstanding: no new request is raised between an accepted request and its response. A request that is not accepted keeps its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| ea | input | 64 | Address to translate |
| pid | input | 20 | Process identifier, indexes the process table |
| ptab_base | input | 56 | Process table base address |
| ptab_size | input | 5 | Process table size code (bytes = 2^(code+12)) |
| req_valid | output | 1 | Memory read request |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 56 | Address of the 8-byte read |
| rsp_valid | input | 1 | Read data is valid |
| rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle end-of-walk strobe |
| fault | output | 1 | Walk failed (valid with done) |
| fault_cause | output | 2 | Bit 0 no-entry, bit 1 bad configuration |
| raddr | output | 56 | Translated real address |
| psize | output | 6 | Final page size in bits |
| leaf_pte | output | 64 | Leaf entry |
| pte_addr | output | 56 | Address the leaf entry was read from |

## Verification
A four-level walk that ends in a 12-bit page and a three-level walk that ends in a 21-bit page use the same root widths. They separate the per-level shrinking of the remaining size from the final masking of the page number field. A single-read leaf, a leaf whose width consumes all the remaining bits (page size zero) and leaves at the eighth and ninth levels test the ends of the depth and width range. The rejections, namely a process identifier just past the table, an invalid mid-tree entry, and widths below 5 or above the remaining size at the root and deeper, are told apart by cause code and by the number of memory reads each one issues. Memory stalls its ready every third cycle, so request holding is exercised on every walk.

// File: rtl/rdx_walk_pkg.sv
`timescale 1ns/1ps
package rdx_walk_pkg;
   localparam int ENT_VALID  = 63;
   localparam int ENT_LEAF   = 62;
   localparam int TSZ_LO     = 56;
   localparam int TSZ_HI     = 60;
   localparam int TSZ_BIAS   = 31;
   localparam int IDX_W      = 5;
   localparam int BASE_LO    = 8;
   localparam int PAGE_LO    = 12;
   localparam int ENT_SHIFT  = 3;
   localparam int PTE_SHIFT  = 4;
   localparam int CAUSE_W    = 2;
   localparam int CAUSE_NOENT  = 0;
   localparam int CAUSE_BADCFG = 1;

   typedef enum logic [2:0] {
      W_IDLE, W_FETCH, W_WAIT, W_DONE, W_FAULT
   } walk_state_e;
endpackage

// File: rtl/rdx_ptab_check.sv
`timescale 1ns/1ps
module rdx_ptab_check
   import rdx_walk_pkg::*;
#(
   parameter int ADDR_W  = 56,
   parameter int PID_W   = 20,
   parameter int TSIZE_W = 5
) (
   input  logic [PID_W-1:0]   pid,
   input  logic [TSIZE_W-1:0] size_code,
   input  logic [ADDR_W-1:0]  tbase,
   output logic               in_range,
   output logic [ADDR_W-1:0]  root_addr
);
   localparam int SH_W = TSIZE_W + 1;
   // offset pid*16 < 2^(code+12)  <=>  pid < 2^(code+8)
   localparam int SH_BIAS = PAGE_LO - PTE_SHIFT;

   logic [SH_W-1:0] shamt;

   always_comb begin
      shamt     = SH_W'(size_code) + SH_W'(SH_BIAS);
      in_range  = (pid >> shamt) == '0;
      root_addr = tbase + ADDR_W'({pid, {PTE_SHIFT{1'b0}}});
   end
endmodule

// File: rtl/rdx_index_calc.sv
`timescale 1ns/1ps
module rdx_index_calc
   import rdx_walk_pkg::*;
#(
   parameter int ADDR_W = 56,
   parameter int EA_W   = 64,
   parameter int RS_W   = 6
) (
   input  logic [EA_W-1:0]   ea,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  width,
   input  logic [RS_W-1:0]   remain,
   output logic [ADDR_W-1:0] ent_addr
);
   logic [RS_W-1:0] shamt;
   logic [EA_W-1:0] keep;
   logic [EA_W-1:0] idx;

   always_comb begin
      shamt    = remain - RS_W'(width);
      keep     = (EA_W'(1) << width) - EA_W'(1);
      idx      = (ea >> shamt) & keep;
      ent_addr = base + ADDR_W'({idx, {ENT_SHIFT{1'b0}}});
   end
endmodule

// File: rtl/rdx_leaf_merge.sv
`timescale 1ns/1ps
module rdx_leaf_merge
   import rdx_walk_pkg::*;
#(
   parameter int ADDR_W = 56,
   parameter int RS_W   = 6
) (
   input  logic [ADDR_W-1:PAGE_LO] page_num,
   input  logic [ADDR_W-1:0]       ea_lo,
   input  logic [RS_W-1:0]         psize,
   output logic [ADDR_W-1:0]       raddr
);
   logic [ADDR_W-1:0] offs_mask;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      assign offs_mask[i] = psize > RS_W'(i);
   end

   assign raddr = ({page_num, {PAGE_LO{1'b0}}} & ~offs_mask) | (ea_lo & offs_mask);
endmodule

// File: rtl/rdx_walk_top.sv
`timescale 1ns/1ps
module rdx_walk_top
   import rdx_walk_pkg::*;
#(
   parameter int ADDR_W     = 56,
   parameter int EA_W       = 64,
   parameter int PID_W      = 20,
   parameter int TSIZE_W    = 5,
   parameter int MAX_LEVELS = 8,
   parameter int MIN_IDX    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [EA_W-1:0]      ea,
   input  logic [PID_W-1:0]     pid,
   input  logic [ADDR_W-1:0]    ptab_base,
   input  logic [TSIZE_W-1:0]   ptab_size,
   output logic                 req_valid,
   input  logic                 req_ready,
   output logic [ADDR_W-1:0]    req_addr,
   input  logic                 rsp_valid,
   input  logic [63:0]          rsp_data,
   output logic                 done,
   output logic                 fault,
   output logic [CAUSE_W-1:0]   fault_cause,
   output logic [ADDR_W-1:0]    raddr,
   output logic [$clog2(EA_W)-1:0] psize,
   output logic [63:0]          leaf_pte,
   output logic [ADDR_W-1:0]    pte_addr
);
   localparam int RS_W = $clog2(EA_W);
   localparam int LV_W = $clog2(MAX_LEVELS + 1);

   if (ADDR_W > TSZ_LO || ADDR_W <= PAGE_LO) begin : g_bad_addr
      $error("ADDR_W must lie between 13 and 56");
   end
   if (EA_W != 64) begin : g_bad_ea
      $error("EA_W must be 64");
   end
   if (MAX_LEVELS < 1 || MIN_IDX < 1 || MIN_IDX >= (1 << IDX_W)) begin : g_bad_lvl
      $error("MAX_LEVELS or MIN_IDX out of range");
   end

   walk_state_e        state;
   logic [EA_W-1:0]    ea_q;
   logic [ADDR_W-1:0]  root_addr_q;
   logic [ADDR_W-1:0]  base_q;
   logic [IDX_W-1:0]   width_q;
   logic [RS_W-1:0]    remain_q;
   logic [LV_W-1:0]    level_q;
   logic               at_root_q;
   logic [CAUSE_W-1:0] cause_q;

   logic               pid_ok;
   logic [ADDR_W-1:0]  root_addr;
   logic [ADDR_W-1:0]  ent_addr;
   logic [ADDR_W-1:0]  leaf_ra;
   logic [RS_W-1:0]    remain_nxt;
   logic               cfg_bad;

   rdx_ptab_check #(.ADDR_W(ADDR_W), .PID_W(PID_W), .TSIZE_W(TSIZE_W)) u_ptab (
      .pid(pid), .size_code(ptab_size), .tbase(ptab_base),
      .in_range(pid_ok), .root_addr(root_addr));

   rdx_index_calc #(.ADDR_W(ADDR_W), .EA_W(EA_W), .RS_W(RS_W)) u_idx (
      .ea(ea_q), .base(base_q), .width(width_q), .remain(remain_q),
      .ent_addr(ent_addr));

   rdx_leaf_merge #(.ADDR_W(ADDR_W), .RS_W(RS_W)) u_merge (
      .page_num(rsp_data[ADDR_W-1:PAGE_LO]), .ea_lo(ea_q[ADDR_W-1:0]),
      .psize(remain_nxt), .raddr(leaf_ra));

   always_comb begin
      remain_nxt = remain_q - RS_W'(width_q);
      cfg_bad    = (width_q < IDX_W'(MIN_IDX)) || (RS_W'(width_q) > remain_q);
      req_valid  = (state == W_FETCH) && (at_root_q || !cfg_bad);
      req_addr   = at_root_q ? root_addr_q : ent_addr;
      done       = (state == W_DONE) || (state == W_FAULT);
      fault      = (state == W_FAULT);
      fault_cause = cause_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= W_IDLE;
         ea_q        <= '0;
         root_addr_q <= '0;
         base_q      <= '0;
         width_q     <= '0;
         remain_q    <= '0;
         level_q     <= '0;
         at_root_q   <= 1'b0;
         cause_q     <= '0;
         raddr       <= '0;
         psize       <= '0;
         leaf_pte    <= '0;
         pte_addr    <= '0;
      end else begin
         case (state)
            W_IDLE: if (start) begin
               ea_q        <= ea;
               root_addr_q <= root_addr;
               level_q     <= '0;
               at_root_q   <= 1'b1;
               cause_q     <= '0;
               if (!pid_ok) begin
                  cause_q[CAUSE_NOENT] <= 1'b1;
                  state <= W_FAULT;
               end else begin
                  state <= W_FETCH;
               end
            end
            W_FETCH: begin
               if (!at_root_q && cfg_bad) begin
                  cause_q[CAUSE_BADCFG] <= 1'b1;
                  state <= W_FAULT;
               end else if (req_ready) begin
                  state <= W_WAIT;
               end
            end
            W_WAIT: if (rsp_valid) begin
               if (at_root_q) begin
                  at_root_q <= 1'b0;
                  base_q    <= {rsp_data[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}};
                  width_q   <= rsp_data[IDX_W-1:0];
                  remain_q  <= RS_W'(rsp_data[TSZ_HI:TSZ_LO]) + RS_W'(TSZ_BIAS);
                  state     <= W_FETCH;
               end else if (!rsp_data[ENT_VALID]) begin
                  cause_q[CAUSE_NOENT] <= 1'b1;
                  state <= W_FAULT;
               end else if (rsp_data[ENT_LEAF]) begin
                  raddr    <= leaf_ra;
                  psize    <= remain_nxt;
                  leaf_pte <= rsp_data;
                  pte_addr <= ent_addr;
                  state    <= W_DONE;
               end else if (level_q == LV_W'(MAX_LEVELS - 1)) begin
                  cause_q[CAUSE_BADCFG] <= 1'b1;
                  state <= W_FAULT;
               end else begin
                  level_q  <= level_q + LV_W'(1);
                  base_q   <= {rsp_data[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}};
                  width_q  <= rsp_data[IDX_W-1:0];
                  remain_q <= remain_nxt;
                  state    <= W_FETCH;
               end
            end
            W_DONE:  state <= W_IDLE;
            W_FAULT: state <= W_IDLE;
            default: state <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rdx_walk_chk.sv
`timescale 1ns/1ps
module rdx_walk_chk #(
   parameter int ADDR_W = 56
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              done,
   input logic              fault,
   input logic [1:0]        fault_cause,
   input logic [1:0]        leaf_flags
);
   logic in_flight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      in_flight <= 1'b0;
      else if (req_valid && req_ready) in_flight <= 1'b1;
      else if (rsp_valid)              in_flight <= 1'b0;
   end

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr));

   // R10
   one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight |-> !req_valid);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done && $countones(fault_cause) == 1);

   // R7
   leaf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault |-> leaf_flags == 2'b11);
endmodule

bind rdx_walk_top rdx_walk_chk #(.ADDR_W(ADDR_W)) u_walk_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_addr(req_addr), .rsp_valid(rsp_valid), .done(done), .fault(fault),
   .fault_cause(fault_cause), .leaf_flags(leaf_pte[63:62]));

// File: tb/rdx_walk_top_tb_top.sv
`timescale 1ns/1ps
module rdx_walk_top_tb_top;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, start;
   logic [63:0] ea;
   logic [19:0] pid;
   logic [55:0] ptab_base;
   logic [4:0]  ptab_size;
   logic        req_valid, req_ready, rsp_valid;
   logic [55:0] req_addr;
   logic [63:0] rsp_data;
   logic        done, fault;
   logic [1:0]  fault_cause;
   logic [55:0] raddr, pte_addr;
   logic [5:0]  psize;
   logic [63:0] leaf_pte;

   rdx_walk_top dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .pid(pid),
      .ptab_base(ptab_base), .ptab_size(ptab_size), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .done(done), .fault(fault), .fault_cause(fault_cause),
      .raddr(raddr), .psize(psize), .leaf_pte(leaf_pte), .pte_addr(pte_addr));

   typedef struct {
      bit        flt;
      bit [1:0]  cause;
      bit [55:0] ra;
      bit [5:0]  ps;
      bit [63:0] pte;
      bit [55:0] pa;
      int        nrd;
      string     tag;
   } exp_t;

   logic [63:0] mem [logic [55:0]];
   exp_t        sb[$];
   int          total = 0, bad = 0, nreads = 0, cyc = 0, dly = 0;
   logic [55:0] pend_addr;
   bit          prev_done = 0, finished = 0;
   localparam logic [55:0] PTB = 56'h10_0000;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rd(logic [55:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   function automatic exp_t model(logic [63:0] a, logic [19:0] p, logic [4:0] sz, string tag);
      exp_t e;
      logic [63:0] root, d, idx, msk;
      logic [55:0] base, ent;
      int w, rem;
      e.flt = 0; e.cause = 0; e.ra = 0; e.ps = 0; e.pte = 0; e.pa = 0; e.nrd = 0; e.tag = tag;
      if ((64'(p) * 16) >= (64'd1 << (sz + 12))) begin
         e.flt = 1; e.cause = 2'b01; return e;
      end
      root = rd(PTB + 56'(p) * 16); e.nrd = 1;
      base = {root[55:8], 8'h00}; w = int'(root[4:0]); rem = int'(root[60:56]) + 31;
      for (int lv = 0; lv < 8; lv++) begin
         if (w < 5 || w > rem) begin e.flt = 1; e.cause = 2'b10; return e; end
         idx = (a >> (rem - w)) & ((64'd1 << w) - 1);
         ent = base + 56'(idx * 8);
         d = rd(ent); e.nrd++;
         if (!d[63]) begin e.flt = 1; e.cause = 2'b01; return e; end
         rem = rem - w;
         if (d[62]) begin
            msk = (64'd1 << rem) - 1;
            e.ra = 56'(({8'h00, d[55:12], 12'h000} & ~msk) | (a & msk));
            e.ps = 6'(rem); e.pte = d; e.pa = ent;
            return e;
         end
         base = {d[55:8], 8'h00}; w = int'(d[4:0]);
      end
      e.flt = 1; e.cause = 2'b10;
      return e;
   endfunction

   // places a root entry and a chain of n tree entries along the path of address a
   task automatic build(logic [63:0] a, logic [19:0] p, int tf, logic [55:0] region,
                        int nl[10], int n, int inval_lvl, logic [55:0] rpn);
      logic [55:0] base, nb, ent;
      logic [63:0] idx;
      int rem;
      mem[PTB + 56'(p) * 16] = {3'b000, 5'(tf), region[55:8], 3'b000, 5'(nl[0])};
      base = region; rem = tf + 31;
      for (int i = 0; i < n; i++) begin
         if (nl[i] < 5 || nl[i] > rem) return;
         idx = (a >> (rem - nl[i])) & ((64'd1 << nl[i]) - 1);
         ent = base + 56'(idx * 8);
         rem = rem - nl[i];
         nb = region + 56'(i + 1) * 56'h100_0000;
         if (i == inval_lvl)  mem[ent] = {2'b00, 6'h0, nb[55:8], 3'b000, 5'd9};
         else if (i == n - 1) mem[ent] = {2'b11, 6'h0, rpn[55:12], 12'h0A5};
         else                 mem[ent] = {2'b10, 6'h0, nb[55:8], 3'b000, 5'(nl[i + 1])};
         base = nb;
      end
   endtask

   task automatic run(logic [63:0] a, logic [19:0] p, logic [4:0] sz, string tag);
      sb.push_back(model(a, p, sz, tag));
      @(negedge clk);
      nreads = 0; ea = a; pid = p; ptab_size = sz; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (done !== 1'b1) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   // memory: ready low every third cycle, data two cycles after acceptance
   initial begin
      req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0;
         if (dly > 0) begin
            dly--;
            if (dly == 0) begin rsp_valid = 1'b1; rsp_data = rd(pend_addr); end
         end
         cyc++;
         req_ready = (cyc % 3) != 0;
         if (req_valid === 1'b1 && req_ready) begin
            pend_addr = req_addr; dly = 2; nreads++;
         end
      end
   end

   // monitor / scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (prev_done) chk("R9 done lasts one cycle", 64'(done), 64'd0);
         prev_done = (done === 1'b1);
         if (done === 1'b1) begin
            if (sb.size() == 0) chk("R9 unexpected done", 64'd1, 64'd0);
            else begin
               e = sb.pop_front();
               chk({e.tag, " fault"}, 64'(fault), 64'(e.flt));
               chk({e.tag, " cause"}, 64'(fault_cause), 64'(e.cause));
               chk({e.tag, " R10 read count"}, 64'(nreads), 64'(e.nrd));
               if (!e.flt) begin
                  chk({e.tag, " R7 raddr"}, 64'(raddr), 64'(e.ra));
                  chk({e.tag, " R7 psize"}, 64'(psize), 64'(e.ps));
                  chk({e.tag, " R7 leaf_pte"}, leaf_pte, e.pte);
                  chk({e.tag, " R7 pte_addr"}, 64'(pte_addr), 64'(e.pa));
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; ea = '0; pid = '0; ptab_base = PTB; ptab_size = '0;
      build(64'hF000_1234_5678_9ABC, 20'd3,  21, 56'h1000_0000, '{13,9,9,9,0,0,0,0,0,0}, 4, -1, 56'h12_3456_789A_B000);
      build(64'h0000_0ABC_DEF0_1357, 20'd7,  21, 56'h2000_0000, '{13,9,9,0,0,0,0,0,0,0}, 3, -1, 56'h00_0777_7734_5000);
      build(64'h0000_0000_7654_3210, 20'd255, 0, 56'h3000_0000, '{5,0,0,0,0,0,0,0,0,0},   1, -1, 56'h00_00CC_C000_0000);
      build(64'h0000_0123_4567_89AB, 20'd256, 10, 56'h4000_0000, '{10,10,0,0,0,0,0,0,0,0}, 2, -1, 56'h00_0055_5500_0000);
      build(64'h0000_0FED_CBA9_8765, 20'd9,  21, 56'h5000_0000, '{13,9,9,9,0,0,0,0,0,0}, 4, 1,  56'h00_0011_1000_0000);
      build(64'h0000_0000_0000_1000, 20'd10, 21, 56'h6000_0000, '{4,0,0,0,0,0,0,0,0,0},   1, -1, 56'h0);
      build(64'h0000_0000_0000_2000, 20'd11, 21, 56'h7000_0000, '{13,4,9,0,0,0,0,0,0,0},  3, -1, 56'h0);
      build(64'h0000_0000_4321_0000, 20'd12, 0,  56'h8000_0000, '{20,12,0,0,0,0,0,0,0,0}, 2, -1, 56'h0);
      build(64'h0000_0000_2468_ACE0, 20'd14, 0,  56'h9000_0000, '{20,11,0,0,0,0,0,0,0,0}, 2, -1, 56'h00_00AA_BBCC_D000);
      build(64'h3C5A_9687_1234_5678, 20'd13, 31, 56'hA000_0000, '{5,5,5,5,5,5,5,5,5,0},   9, -1, 56'h00_0099_0000_0000);
      build(64'h3C5A_9687_8765_4321, 20'd15, 31, 56'hB000_0000, '{5,5,5,5,5,5,5,5,0,0},   8, -1, 56'h00_0088_0000_0000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset done", 64'(done), 64'd0);
      chk("R9 reset fault", 64'(fault), 64'd0);
      chk("R9 reset req_valid", 64'(req_valid), 64'd0);
      run(64'hF000_1234_5678_9ABC, 20'd3,   5'd0, "R2 R3 R6 R7 four levels");
      run(64'h0000_0ABC_DEF0_1357, 20'd7,   5'd0, "R3 R6 R7 large page");
      run(64'h0000_0000_7654_3210, 20'd255, 5'd0, "R1 last pid in table");
      run(64'h0000_0123_4567_89AB, 20'd256, 5'd0, "R1 pid past table");
      run(64'h0000_0123_4567_89AB, 20'd256, 5'd1, "R1 R2 larger table");
      run(64'h0000_0FED_CBA9_8765, 20'd9,   5'd0, "R5 invalid entry");
      run(64'h0000_0000_0000_1000, 20'd10,  5'd0, "R4 root width 4");
      run(64'h0000_0000_0000_2000, 20'd11,  5'd0, "R4 directory width 4");
      run(64'h0000_0000_4321_0000, 20'd12,  5'd0, "R4 width above remaining");
      run(64'h0000_0000_2468_ACE0, 20'd14,  5'd0, "R4 R7 width equals remaining");
      run(64'h3C5A_9687_1234_5678, 20'd13,  5'd0, "R8 ninth level");
      run(64'h3C5A_9687_8765_4321, 20'd15,  5'd0, "R8 leaf at eighth level");
      chk("R9 scoreboard drained", 64'(sb.size()), 64'd0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule